// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers 51 interrupt sources and drives two request lines toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source is either level-sensitive or edge-sensitive. A level source's pending bit tracks its input. An edge source latches a pending bit when it sees a rising edge, a falling edge or any transition, as chosen per source. Per-source enable and route bits then decide whether a pending source reaches the normal or the fast line.

Software reaches the controller over a plain 32-bit register port. Every 51-bit quantity is split into a low word (sources 0 to 31) and a high word (sources 32 to 50), and address bit 2 picks the high word. The enable bits and the edge latches are changed through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. The sensing mode and the dual-edge choice are fixed by parameters. Only the polarity of the top four sources can be changed at run time.

Top module: `vic_dual_out`

## Requirements
- R1: After reset both request lines are low. Enable, route and pending read as 0. Sensitivity reads 0x1F07FFF8FFFF, dual-edge reads 0xF800070000 and polarity reads 0x5F07FFF8FFFF (as {high word, low word}).
- R2: Address bit 2 selects the high word. High-word bit k is source 32+k. Bits 31:19 of any high-word read are 0.
- R3: A level-sensitive source (sensitivity bit 1) with polarity bit 1 has its pending bit equal to its input, sampled each clock.
- R4: An edge-sensitive source (sensitivity 0, dual-edge 0) latches its pending bit on a rising edge when its polarity is 1 and on a falling edge when its polarity is 0. The bit stays set until it is cleared through edge-clear, even with no further edges.
- R5: An edge-sensitive source with its dual-edge bit set latches on either transition.
- R6: Writing ones to enable-set (0xA0) sets enable bits. Writing ones to enable-clear (0xA8) clears them. Zero bits leave enable unchanged.
- R7: A write to the route register (0x98) replaces the addressed 32-bit half. A pending, enabled source drives `fiq_o` when its route bit is 1 and `irq_o` when it is 0.
- R8: 0x80 reads pending AND enable AND NOT route. 0x88 reads pending AND enable AND route. 0xE0 reads pending AND NOT sensitivity. 0x90 reads pending.
- R9: Ones written to edge-clear (0xD8) clear pending bits of edge-sensitive sources only. Level sources are unaffected.
- R10: At 0xD0, only high-word bits 18:15 (sources 47 to 50) are writable. Writes to the low word and to other bits are ignored. The written polarity takes effect on later edges.
- R11: Reads of 0xA8, 0xB0, 0xB8, 0xD8 and unmapped offsets return 0. Writes to read-only offsets, to 0xB0/0xB8, to offsets below 0x80, and any access with address bits 1:0 nonzero have no effect.
- R12: `irq_o` and `fiq_o` are registered. They reflect an input sample or a register write on the same clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 51 | Interrupt inputs, synchronous to clk_i |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every one of the 51 sources is exercised on its own, with the stimulus chosen by its reset configuration. Level sources get a high-then-low pulse. Dual-edge sources get a rise and a fall, each cleared in between. Single-edge sources get both directions, with a hold period, so the latch and the polarity are separated from simple level following. Odd sources are routed to the fast line and even ones to the normal line, so a swapped route shows up on half of the sweep. Directed sequences then cover the status views, the split of edge-clear between level and edge sources, the limited polarity write, and accesses that must change nothing.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] A_IRQ_ST = 8'h80;
  localparam logic [ADDR_W-1:0] A_FIQ_ST = 8'h88;
  localparam logic [ADDR_W-1:0] A_RAW    = 8'h90;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 8'h98;
  localparam logic [ADDR_W-1:0] A_EN_SET = 8'hA0;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 8'hA8;
  localparam logic [ADDR_W-1:0] A_SW_SET = 8'hB0;
  localparam logic [ADDR_W-1:0] A_SW_CLR = 8'hB8;
  localparam logic [ADDR_W-1:0] A_SENSE  = 8'hC0;
  localparam logic [ADDR_W-1:0] A_DUAL   = 8'hC8;
  localparam logic [ADDR_W-1:0] A_POL    = 8'hD0;
  localparam logic [ADDR_W-1:0] A_ECLR   = 8'hD8;
  localparam logic [ADDR_W-1:0] A_EDGE_ST = 8'hE0;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic sense_i,
  input  logic dual_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_d_o,
  output logic raw_q_o
);
  logic prev_q;
  logic raw_q;
  logic edge_hit;
  logic lvl_val;

  assign lvl_val  = pol_i ? src_i : ~src_i;
  assign edge_hit = dual_i ? (src_i ^ prev_q)
                  : (pol_i ? (src_i & ~prev_q) : (~src_i & prev_q));
  // a new edge wins over a clear in the same cycle
  assign raw_d_o  = sense_i ? lvl_val : ((raw_q & ~clr_i) | edge_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= src_i;
      raw_q  <= raw_d_o;
    end
  end

  assign raw_q_o = raw_q;

  // R3
  lvl_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i |=> raw_q == $past(pol_i ? src_i : !src_i));
  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i && raw_q && !clr_i) |=> raw_q);
  // R9
  edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i && clr_i && !edge_hit) |=> !raw_q);
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned  NSRC     = 51,
  parameter int unsigned  POL_WR_N = 4,
  parameter logic [63:0]  POL_RST  = 64'h5F07FFF8FFFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic                 hi_i,
  input  logic [ADDR_W-1:0]    ofs_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [NSRC-1:0]      raw_q_i,
  input  logic [NSRC-1:0]      sense_i,
  input  logic [NSRC-1:0]      dual_i,
  output logic [NSRC-1:0]      en_d_o,
  output logic [NSRC-1:0]      sel_d_o,
  output logic [NSRC-1:0]      en_q_o,
  output logic [NSRC-1:0]      sel_q_o,
  output logic [NSRC-1:0]      pol_o,
  output logic [NSRC-1:0]      eclr_o,
  output logic [WORD_W-1:0]    rdata_o
);
  localparam int unsigned HI_W = NSRC - WORD_W;
  localparam logic [NSRC-1:0] POL_WMASK =
    {{POL_WR_N{1'b1}}, {(NSRC-POL_WR_N){1'b0}}};

  logic [NSRC-1:0] en_q, sel_q, pol_q;
  logic [NSRC-1:0] wvec, half;
  logic [NSRC-1:0] rvec;

  always_comb begin
    for (int b = 0; b < int'(NSRC); b++) begin
      if (hi_i) begin
        wvec[b] = (b >= int'(WORD_W)) ? wdata_i[b-int'(WORD_W)] : 1'b0;
        half[b] = (b >= int'(WORD_W));
      end else begin
        wvec[b] = (b < int'(WORD_W)) ? wdata_i[b] : 1'b0;
        half[b] = (b < int'(WORD_W));
      end
    end
  end

  logic wr_route, wr_en_set, wr_en_clr, wr_pol, wr_eclr;
  assign wr_route  = wr_i && (ofs_i == A_ROUTE);
  assign wr_en_set = wr_i && (ofs_i == A_EN_SET);
  assign wr_en_clr = wr_i && (ofs_i == A_EN_CLR);
  assign wr_pol    = wr_i && (ofs_i == A_POL) && hi_i;
  assign wr_eclr   = wr_i && (ofs_i == A_ECLR);

  always_comb begin
    en_d_o = en_q;
    if (wr_en_set)      en_d_o = en_q | wvec;
    else if (wr_en_clr) en_d_o = en_q & ~wvec;
  end

  assign sel_d_o = wr_route ? ((sel_q & ~half) | wvec) : sel_q;
  assign eclr_o  = wr_eclr ? (wvec & ~sense_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sel_q <= '0;
      pol_q <= POL_RST[NSRC-1:0];
    end else begin
      en_q  <= en_d_o;
      sel_q <= sel_d_o;
      if (wr_pol) pol_q <= (pol_q & ~POL_WMASK) | (wvec & POL_WMASK);
    end
  end

  always_comb begin
    unique case (ofs_i)
      A_IRQ_ST:  rvec = raw_q_i & en_q & ~sel_q;
      A_FIQ_ST:  rvec = raw_q_i & en_q & sel_q;
      A_RAW:     rvec = raw_q_i;
      A_ROUTE:   rvec = sel_q;
      A_EN_SET:  rvec = en_q;
      A_SENSE:   rvec = sense_i;
      A_DUAL:    rvec = dual_i;
      A_POL:     rvec = pol_q;
      A_EDGE_ST: rvec = raw_q_i & ~sense_i;
      default:   rvec = '0;
    endcase
  end

  assign rdata_o = !rd_i ? '0
                 : hi_i ? {{(WORD_W-HI_W){1'b0}}, rvec[NSRC-1:WORD_W]}
                 : rvec[WORD_W-1:0];

  assign en_q_o  = en_q;
  assign sel_q_o = sel_q;
  assign pol_o   = pol_q;

  // R6
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_set |=> (en_q & $past(wvec)) == $past(wvec));
  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_clr |=> (en_q & $past(wvec)) == '0);
  // R10
  pol_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pol_q & ~POL_WMASK));
endmodule

// File: rtl/vic_dual_out.sv
module vic_dual_out
  import vic_pkg::*;
#(
  parameter int unsigned NSRC      = 51,
  parameter int unsigned POL_WR_N  = 4,
  parameter logic [63:0] SENSE_CFG = 64'h1F07FFF8FFFF,
  parameter logic [63:0] DUAL_CFG  = 64'hF800070000,
  parameter logic [63:0] POL_RST   = 64'h5F07FFF8FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic in_win;
  logic [ADDR_W-1:0] ofs;
  logic [NSRC-1:0] raw_d, raw_q, en_d, sel_d, en_q, sel_q, pol, eclr;
  logic [NSRC-1:0] sense_v, dual_v;

  assign sense_v = SENSE_CFG[NSRC-1:0];
  assign dual_v  = DUAL_CFG[NSRC-1:0];
  // window is 0x80..0xFF, word aligned only
  assign in_win  = bus_req_i && bus_addr_i[ADDR_W-1] && (bus_addr_i[1:0] == 2'b00);
  assign ofs     = {bus_addr_i[ADDR_W-1:3], 3'b000};

  vic_regs #(.NSRC(NSRC), .POL_WR_N(POL_WR_N), .POL_RST(POL_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (in_win && bus_we_i),
    .rd_i    (in_win && !bus_we_i),
    .hi_i    (bus_addr_i[2]),
    .ofs_i   (ofs),
    .wdata_i (bus_wdata_i),
    .raw_q_i (raw_q),
    .sense_i (sense_v),
    .dual_i  (dual_v),
    .en_d_o  (en_d),
    .sel_d_o (sel_d),
    .en_q_o  (en_q),
    .sel_q_o (sel_q),
    .pol_o   (pol),
    .eclr_o  (eclr),
    .rdata_o (bus_rdata_o)
  );

  for (genvar g = 0; g < int'(NSRC); g++) begin : g_src
    vic_src_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[g]),
      .sense_i (sense_v[g]),
      .dual_i  (dual_v[g]),
      .pol_i   (pol[g]),
      .clr_i   (eclr[g]),
      .raw_d_o (raw_d[g]),
      .raw_q_o (raw_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |(raw_d & en_d & ~sel_d);
      fiq_o <= |(raw_d & en_d & sel_d);
    end
  end

  // R7
  fiq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> |(raw_q & en_q & sel_q));
  // R7
  irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(raw_q & en_q & ~sel_q));
endmodule

// File: tb/vic_dual_out_tb_top.sv
module vic_dual_out_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 51;
  localparam logic [63:0] SENSE_RST = 64'h1F07FFF8FFFF;
  localparam logic [63:0] DUAL_RST  = 64'hF800070000;
  localparam logic [63:0] POL_RST   = 64'h5F07FFF8FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_dual_out dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic drive(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic line_chk(input string tag, input logic to_fiq, input logic v);
    chk({tag, " irq"}, 64'(irq), 64'(v & !to_fiq));
    chk({tag, " fiq"}, 64'(fiq), 64'(v & to_fiq));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 fiq", 64'(fiq), 0);
    for (int h = 0; h < 2; h++) begin
      rd(8'h90 | 8'(h*4), d); chk("R1 raw", 64'(d), 0);
      rd(8'hA0 | 8'(h*4), d); chk("R1 enable", 64'(d), 0);
      rd(8'h98 | 8'(h*4), d); chk("R1 route", 64'(d), 0);
      rd(8'hC0 | 8'(h*4), d); chk("R1 sense", 64'(d), 64'(SENSE_RST[h*32 +: 32]));
      rd(8'hC8 | 8'(h*4), d); chk("R1 dual", 64'(d), 64'(DUAL_RST[h*32 +: 32]));
      rd(8'hD0 | 8'(h*4), d); chk("R1 pol", 64'(d), 64'(POL_RST[h*32 +: 32]));
    end

    // sweep every source on its reset configuration; odd sources to fast line
    for (int i = 0; i < N; i++) begin
      automatic logic [7:0]  ho = (i >= 32) ? 8'h4 : 8'h0;
      automatic logic [31:0] bm = 32'h1 << (i % 32);
      automatic logic        f  = i[0];
      wr(8'hA0 | ho, bm);
      wr(8'h98 | ho, f ? bm : 32'h0);
      if (SENSE_RST[i]) begin
        drive(i, 1'b1); line_chk("R3 level high", f, 1'b1);
        rd(8'h90 | ho, d); chk("R3 raw", 64'(d & bm), 64'(bm));
        drive(i, 1'b0); line_chk("R3 level low", f, 1'b0);
      end else if (DUAL_RST[i]) begin
        drive(i, 1'b1); line_chk("R5 rise", f, 1'b1);
        wr(8'hD8 | ho, bm); line_chk("R9 clear", f, 1'b0);
        drive(i, 1'b0); line_chk("R5 fall", f, 1'b1);
        wr(8'hD8 | ho, bm); line_chk("R9 clear", f, 1'b0);
      end else begin
        automatic logic e = POL_RST[i];
        drive(i, 1'b1); line_chk("R4 rise", f, e);
        repeat (3) @(negedge clk);
        line_chk("R4 hold", f, e);
        wr(8'hD8 | ho, bm); line_chk("R4 clear", f, 1'b0);
        drive(i, 1'b0); line_chk("R4 fall", f, !e);
        wr(8'hD8 | ho, bm); line_chk("R4 clear", f, 1'b0);
      end
      wr(8'hA8 | ho, bm);
      wr(8'h98 | ho, 32'h0);
    end

    // R12 output follows a register write on the capturing edge
    drive(0, 1'b1);
    chk("R12 before enable", 64'(irq), 0);
    wr(8'hA0, 32'h1);
    chk("R12 after enable", 64'(irq), 1);
    // R8 status views
    rd(8'h80, d); chk("R8 irq status", 64'(d), 1);
    rd(8'h88, d); chk("R8 fiq status", 64'(d), 0);
    wr(8'h98, 32'h1);
    line_chk("R7 reroute", 1'b1, 1'b1);
    rd(8'h88, d); chk("R8 fiq status", 64'(d), 1);
    rd(8'h80, d); chk("R8 irq status", 64'(d), 0);
    drive(16, 1'b1);
    rd(8'hE0, d); chk("R8 edge status", 64'(d), 64'h10000);
    // R9 edge-clear spares level source 0
    wr(8'hD8, 32'h0001_0001);
    rd(8'h90, d); chk("R9 level kept", 64'(d), 1);
    drive(16, 1'b0);
    wr(8'hD8, 32'h0001_0000);
    drive(0, 1'b0);
    wr(8'hA8, 32'h1);
    wr(8'h98, 32'h0);

    // R2 word split
    drive(40, 1'b1);
    rd(8'h94, d); chk("R2 raw high", 64'(d), 64'h100);
    rd(8'h90, d); chk("R2 raw low", 64'(d), 0);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, d); chk("R2 high width", 64'(d), 64'h7FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd(8'hA4, d); chk("R6 clear all", 64'(d), 0);
    drive(40, 1'b0);

    // R10 polarity write limited to sources 47..50
    wr(8'hD4, 32'hFFFF_FFFF);
    rd(8'hD4, d); chk("R10 pol high", 64'(d), 64'h7DF07);
    wr(8'hD0, 32'h0);
    rd(8'hD0, d); chk("R10 pol low", 64'(d), 64'hFFF8FFFF);
    drive(47, 1'b1);
    rd(8'h94, d); chk("R10 rising now", 64'(d), 64'h8000);
    wr(8'hDC, 32'h8000);
    wr(8'hD4, 32'h0);
    rd(8'hD4, d); chk("R10 pol restore", 64'(d), 64'h5F07);
    drive(47, 1'b0);
    rd(8'h94, d); chk("R10 falling again", 64'(d), 64'h8000);
    wr(8'hDC, 32'h8000);
    rd(8'h94, d); chk("R9 cleared", 64'(d), 0);

    // R11 ignored accesses
    rd(8'hA8, d); chk("R11 wo read", 64'(d), 0);
    rd(8'hD8, d); chk("R11 wo read", 64'(d), 0);
    rd(8'hE8, d); chk("R11 unmapped", 64'(d), 0);
    rd(8'hB0, d); chk("R11 sw read", 64'(d), 0);
    drive(0, 1'b1);
    wr(8'h90, 32'h0);
    rd(8'h90, d); chk("R11 raw ro", 64'(d), 1);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'hA1, 32'hFFFF_FFFF);
    wr(8'hB0, 32'hFFFF_FFFF);
    rd(8'hA0, d); chk("R11 enable untouched", 64'(d), 0);
    chk("R11 irq", 64'(irq), 0);
    wr(8'hC0, 32'h0);
    rd(8'hC0, d); chk("R11 sense ro", 64'(d), 64'hFFF8FFFF);
    drive(0, 1'b0);

    finish_run();
  end
endmodule